// File: doc/BRIEF.md
# Packed BCD Decimal Adjust

This block corrects an 8-bit accumulator value that was produced by binary addition of two packed-BCD bytes, so that it again holds two valid decimal digits. It takes the raw sum, the carry flag and the half-carry (bit-3 carry) flag left by that addition. It returns the corrected byte and the updated carry flag. The overflow flag goes through untouched.

The correction has two stages, and their order matters. The low digit is fixed first. A carry out of the byte caused by that fix feeds the decision for the high digit. The carry flag can be set by either stage, but nothing in the block ever clears it. For that reason the carry output tells whether the decimal sum reached 100, which allows multi-byte decimal additions to be chained.

The whole correction is one combinational pass. Its result is registered in a single output stage, so every result appears one clock after its inputs. A reset clears the registered outputs.

Top module: `bcd_dec_adjust`

## Requirements
- R1: When the low nibble of `acc_in` (bits 3:0) is greater than 9, or `ac_in` is 1, the first stage adds 06h to the whole byte. Otherwise it adds nothing.
- R2: A carry out of bit 7 produced by the first-stage addition sets the carry output. For example, FAh with both flags 0 gives 60h with carry 1.
- R3: After the first stage, 60h is added when the running carry is 1 or the high nibble (bits 7:4) is greater than 9. For example, BEh with both flags 0 gives 24h, and C9h gives 29h.
- R4: A carry out of bit 7 produced by the second-stage addition sets the carry output. For example, A0h with both flags 0 gives 00h with carry 1.
- R5: The carry output is 1 whenever `cy_in` is 1. The block never clears the carry.
- R6: The output byte always differs from the input byte by 00h, 06h, 60h or 66h (modulo 256).
- R7: `ov_out` equals `ov_in`, whatever the other inputs are.
- R8: Outputs are registered and reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, `acc_out`, `cy_out` and `ov_out` are 0.
- R9: Take any two packed-BCD bytes X and Y (0 to 99) and a carry-in K. Add them in binary, with `ac_in` set to the carry out of bit 3 and `cy_in` set to the carry out of bit 7. After adjustment the byte holds the packed BCD of (X+Y+K) mod 100, and the carry output is 1 exactly when X+Y+K is at least 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_in | input | 8 | Raw binary sum to be adjusted |
| cy_in | input | 1 | Carry flag left by the addition |
| ac_in | input | 1 | Half-carry (bit 3 carry) flag left by the addition |
| ov_in | input | 1 | Overflow flag, carried through unchanged |
| acc_out | output | 8 | Adjusted packed-BCD byte |
| cy_out | output | 1 | Updated carry flag |
| ov_out | output | 1 | Overflow flag, equal to the registered `ov_in` |

## Verification
The main stimulus is an exhaustive sweep over every pair of valid BCD operands, each with carry-in 0 and 1. The results are compared against a purely decimal sum, which exercises every combination of digit overflow and half-carry that real additions produce.

Directed bytes are added for cases a valid addition rarely isolates:
- a low nibble above 9 on its own, and the half-carry on its own, which separate the two triggers of the first stage;
- FAh, where only the ripple from the low fix forces the high fix;
- A0h, where the carry comes only from the high fix;
- a set incoming carry on a small byte, which shows that the carry is sticky and can trigger the high fix by itself.

The overflow flag is toggled independently throughout, which shows that it passes through.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    localparam int DATA_W    = 8;
    localparam int NIB_W     = 4;
    localparam int NIBS      = DATA_W / NIB_W;
    localparam int DIGIT_MAX = 9;
    localparam int FIX_STEP  = 6;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              cy;
        logic              ov;
    } adj_res_t;

endpackage

// File: rtl/bcd_nib_stage.sv
module bcd_nib_stage
    import bcd_adj_pkg::*;
#(
    parameter int POS = 0
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              force_i,
    output logic [DATA_W-1:0] val_o,
    output logic              carry_o
);

    localparam logic [DATA_W:0] ADDEND = (DATA_W+1)'(FIX_STEP) << (POS * NIB_W);

    logic [NIB_W-1:0] digit;
    logic             need_fix;
    logic [DATA_W:0]  wide_sum;

    always_comb begin
        digit    = val_i[POS*NIB_W +: NIB_W];
        need_fix = force_i || (digit > NIB_W'(DIGIT_MAX));
        wide_sum = {1'b0, val_i} + (need_fix ? ADDEND : '0);
        val_o    = wide_sum[DATA_W-1:0];
        carry_o  = wide_sum[DATA_W];
    end

endmodule

// File: rtl/bcd_dec_adjust.sv
module bcd_dec_adjust
    import bcd_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              cy_in,
    input  logic              ac_in,
    input  logic              ov_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              cy_out,
    output logic              ov_out
);

    // chain of values between stages, low digit first
    logic [DATA_W-1:0] val_chain [NIBS+1];
    logic [NIBS:0]     cy_chain;
    logic [NIBS-1:0]   stage_carry;
    logic [NIBS-1:0]   stage_force;

    assign val_chain[0] = acc_in;
    assign cy_chain[0]  = cy_in;

    for (genvar k = 0; k < NIBS; k++) begin : g_stage
        // low digit is forced by the half-carry, upper by the running carry
        if (k == 0) begin : g_low
            assign stage_force[k] = ac_in;
        end else begin : g_high
            assign stage_force[k] = cy_chain[k];
        end

        bcd_nib_stage #(.POS(k)) u_stage (
            .val_i   (val_chain[k]),
            .force_i (stage_force[k]),
            .val_o   (val_chain[k+1]),
            .carry_o (stage_carry[k])
        );

        // carry is sticky: only ever ORed in
        assign cy_chain[k+1] = cy_chain[k] | stage_carry[k];
    end

    adj_res_t res_d, res_q;

    always_comb begin
        res_d.acc = val_chain[NIBS];
        res_d.cy  = cy_chain[NIBS];
        res_d.ov  = ov_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign acc_out = res_q.acc;
    assign cy_out  = res_q.cy;
    assign ov_out  = res_q.ov;

endmodule

// File: rtl/bcd_dec_adjust_chk.sv
module bcd_dec_adjust_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] acc_in,
    input logic       cy_in,
    input logic       ac_in,
    input logic       ov_in,
    input logic [7:0] acc_out,
    input logic       cy_out,
    input logic       ov_out
);

    // R1: a triggered low fix leaves the low nibble advanced by six
    p_lo_fix_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_in[3:0] > 4'd9) || ac_in) |=> (acc_out[3:0] == 4'($past(acc_in[3:0]) + 4'd6)));

    // R1 R3: valid digits with no flags pass unchanged
    p_no_fix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ac_in && !cy_in && acc_in[3:0] <= 4'd9 && acc_in[7:4] <= 4'd9)
        |=> (acc_out == $past(acc_in)) && !cy_out);

    // R3: incoming carry alone forces the high fix
    p_hi_fix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_in && !ac_in && acc_in[3:0] <= 4'd9) |=> (acc_out == 8'($past(acc_in) + 8'h60)));

    // R5: carry is never cleared
    p_cy_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cy_in |=> cy_out);

    // R6: only four correction amounts exist
    p_delta_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((8'(acc_out - $past(acc_in)) == 8'h00) || (8'(acc_out - $past(acc_in)) == 8'h06) ||
                   (8'(acc_out - $past(acc_in)) == 8'h60) || (8'(acc_out - $past(acc_in)) == 8'h66)));

    // R7: overflow passes through
    p_ov_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ov_out == $past(ov_in)));

endmodule

bind bcd_dec_adjust bcd_dec_adjust_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_in  (acc_in),
    .cy_in   (cy_in),
    .ac_in   (ac_in),
    .ov_in   (ov_in),
    .acc_out (acc_out),
    .cy_out  (cy_out),
    .ov_out  (ov_out)
);

// File: tb/sim_bcd_dec_adjust.sv
module sim_bcd_dec_adjust;

    typedef struct {
        logic [7:0] acc;
        logic       cy;
        logic       ov;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic       cy_in = 1'b0;
    logic       ac_in = 1'b0;
    logic       ov_in = 1'b0;
    logic [7:0] acc_out;
    logic       cy_out;
    logic       ov_out;

    int   n_vec  = 0;
    int   n_bad  = 0;
    int   cycles = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    bcd_dec_adjust u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_in  (acc_in),
        .cy_in   (cy_in),
        .ac_in   (ac_in),
        .ov_in   (ov_in),
        .acc_out (acc_out),
        .cy_out  (cy_out),
        .ov_out  (ov_out)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic drive(input logic [7:0] a, input logic c, input logic h, input logic o,
                         input logic [7:0] ea, input logic ec, input string tag);
        exp_t e;
        @(negedge clk);
        acc_in = a; cy_in = c; ac_in = h; ov_in = o;
        e.acc = ea; e.cy = ec; e.ov = o; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: one result per cycle, just after the edge that registers it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (acc_out !== e.acc || cy_out !== e.cy || ov_out !== e.ov) begin
                    n_bad++;
                    $display("FAIL %s: got acc=%h cy=%b ov=%b expected acc=%h cy=%b ov=%b",
                             e.tag, acc_out, cy_out, ov_out, e.acc, e.cy, e.ov);
                end
            end
        end
    end

    initial begin
        // R8: reset state
        acc_in = 8'h99; cy_in = 1'b1; ov_in = 1'b1;
        repeat (3) @(negedge clk);
        n_vec++;
        if (acc_out !== 8'h00 || cy_out !== 1'b0 || ov_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 reset: got acc=%h cy=%b ov=%b expected acc=00 cy=0 ov=0",
                     acc_out, cy_out, ov_out);
        end
        rst_n = 1'b1;

        drive(8'h2B, 1'b0, 1'b0, 1'b0, 8'h31, 1'b0, "R1 low nibble over nine");
        drive(8'h21, 1'b0, 1'b1, 1'b1, 8'h27, 1'b0, "R1 half-carry alone");
        drive(8'h45, 1'b0, 1'b0, 1'b0, 8'h45, 1'b0, "R1 R3 no correction");
        drive(8'hFA, 1'b0, 1'b0, 1'b0, 8'h60, 1'b1, "R2 ripple from low fix");
        drive(8'hBE, 1'b0, 1'b0, 1'b1, 8'h24, 1'b1, "R3 both digits over nine");
        drive(8'hC9, 1'b0, 1'b0, 1'b0, 8'h29, 1'b1, "R3 high nibble only");
        drive(8'hA0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R4 carry from high fix");
        drive(8'h12, 1'b1, 1'b0, 1'b0, 8'h72, 1'b1, "R5 sticky carry");
        drive(8'h00, 1'b1, 1'b1, 1'b1, 8'h66, 1'b1, "R5 R6 both flags");
        drive(8'h99, 1'b0, 1'b0, 1'b1, 8'h99, 1'b0, "R7 ov set passes");

        // R9: every BCD operand pair, both carry-in values
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [8:0] raw;
                    logic [4:0] lo;
                    int         tot;
                    raw = 9'(to_bcd(x)) + 9'(to_bcd(y)) + 9'(k);
                    lo  = 5'(x % 10) + 5'(y % 10) + 5'(k);
                    tot = x + y + k;
                    drive(raw[7:0], raw[8], lo[4], 1'((x ^ y) & 1),
                          to_bcd(tot % 100), tot >= 100, "R9 decimal sum");
                end
            end
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion expected completion within 100000 cycles");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule